// File: doc/BRIEF.md
# Automatic Clock Source Selector

This block decides which clock a converter runs from when it wakes up. It runs on a free-running reference clock taken from the internal oscillator. It measures the activity on the external clock pin over a fixed window of reference cycles. If it sees enough rising edges, it hands the converter to the external source and switches the internal oscillator off. If the pin is tied low or toggles too slowly, the internal oscillator stays selected and running. The choice is made once per wake-up and then held.

A power-down pin, active low, wraps the whole sequence. A low level that lasts long enough shuts off every source, including the crystal amplifier, drops the ready flag and clears the decision. When the pin returns high, detection runs again. The ready flag rises only after a wake-up delay that depends on the chosen source: a short one for a driven external clock, a medium one for the internal oscillator, and a long one for a crystal. A board strap says whether a crystal is fitted. Every window, threshold and delay is a cycle-count parameter.

Top module: `clk_src_sel`

## Requirements
- R1: While reset is held, clk_ready=0, use_ext_clk=0 and int_osc_en=1, because the oscillator must run for detection to take place.
- R2: If the synchronised external pin shows at least EDGE_THR rising edges in the WIN_CYC-cycle detection window, the block ends in the ready state with use_ext_clk=1 and int_osc_en=0.
- R3: If the pin is idle, or shows fewer than EDGE_THR rising edges in the window, the block ends ready with use_ext_clk=0 and int_osc_en=1.
- R4: Once clk_ready is high, later activity on the external pin, including the pin stopping, does not change use_ext_clk, int_osc_en or clk_ready.
- R5: A power-down pin held low for PD_MIN_CYC or more reference cycles drives clk_ready, int_osc_en, xtal_amp_en and use_ext_clk to 0, and the pulse ends the ready state.
- R6: A low pulse on the power-down pin shorter than PD_MIN_CYC cycles is ignored. clk_ready stays high and the selection is unchanged.
- R7: When the power-down pin returns high after a valid power-down, detection runs again, and the new decision reflects the pin activity at that time.
- R8: After the detection window, clk_ready rises after a wake-up delay of DLY_EXT_CYC cycles for a driven external clock, DLY_XTAL_CYC cycles for a detected crystal, or DLY_INT_CYC cycles for the internal oscillator. These delays add to the window and to a few cycles of synchroniser latency.
- R9: xtal_amp_en is 1 during detection and after selection only if xtal_fitted=1 and the external source was chosen. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock from the internal oscillator |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| pwr_on_pin | input | 1 | Asynchronous power-down pin, low = power down |
| ext_clk_pin | input | 1 | Asynchronous external clock or crystal pin |
| xtal_fitted | input | 1 | Static strap, 1 = crystal fitted across the clock pins |
| use_ext_clk | output | 1 | 1 = converter clock taken from the external pin |
| int_osc_en | output | 1 | Internal oscillator enable |
| xtal_amp_en | output | 1 | Crystal amplifier enable |
| clk_ready | output | 1 | Chosen clock is settled and usable |

## Verification
The hardest situations to reach from the ports are the two sides of the power-down filter. A pulse one cycle short of PD_MIN_CYC must leave a running block untouched. A pulse of exactly PD_MIN_CYC must tear it down and start a new detection. The stimulus drives the pin low for an exact number of cycles, aligned to the falling clock edge, while a fast external clock is selected. A monitor counts every fall of clk_ready, and the scoreboard flags any rise of clk_ready that was not expected. Different external periods and strap settings are applied during power-down, so each wake-up tests a new decision and its own source-specific delay.

// File: rtl/css_pkg.sv
// Shared types and helpers for the clock source selector.
// Assumes: nothing beyond IEEE 1800-2017 elaboration.
package css_pkg;

    typedef enum logic [1:0] {
        CSS_OFF    = 2'd0,
        CSS_DETECT = 2'd1,
        CSS_WAKE   = 2'd2,
        CSS_RUN    = 2'd3
    } css_state_t;

    // Largest of three cycle counts, used to size the wake timer.
    function automatic int unsigned css_max3(input int unsigned a,
                                             input int unsigned b,
                                             input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/css_sync.sv
// Two-stage synchroniser for W independent single-bit asynchronous inputs.
// Assumes: each bit is a level or a slow clock, with no multi-bit coherence needed.
module css_sync #(
    parameter int unsigned    W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  d,
    output logic [W-1:0]  q
);

    logic [W-1:0] meta_q;

    // Shift the asynchronous inputs through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end

endmodule

// File: rtl/css_edge_meter.sv
// Counts rising edges of a synchronised signal across a window of WIN_CYC
// cycles that starts when 'active' rises. Reports 'done' in the last window
// cycle and 'found' once at least EDGE_THR edges were seen.
// Assumes: the input toggles slower than half the reference clock.
module css_edge_meter #(
    parameter int unsigned WIN_CYC  = 4096,
    parameter int unsigned EDGE_THR = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic sig,
    output logic done,
    output logic found
);

    localparam int unsigned WW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
    localparam int unsigned EW = $clog2(EDGE_THR + 1);

    logic          sig_d;
    logic          rise;
    logic [WW-1:0] win_q;
    logic [EW-1:0] edges_q;

    assign rise = sig & ~sig_d;

    // Delay the signal by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sig_d <= 1'b0;
        else        sig_d <= sig;
    end

    // Step the window position and count edges, saturating at the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            win_q   <= '0;
            edges_q <= '0;
        end else begin
            win_q <= win_q + 1'b1;
            if (rise && edges_q != EW'(EDGE_THR))
                edges_q <= edges_q + 1'b1;
        end
    end

    assign done  = active && (win_q == WW'(WIN_CYC - 1));
    assign found = (edges_q == EW'(EDGE_THR));

endmodule

// File: rtl/css_pd_filter.sv
// Qualifies the synchronised power-down pin. It asserts 'pd_act' only after
// the pin has stayed low for PD_MIN_CYC consecutive cycles, and holds it
// while the pin stays low.
// Assumes: pin_s is already synchronised; 1 = run, 0 = power-down request.
module css_pd_filter #(
    parameter int unsigned PD_MIN_CYC = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    output logic pd_act
);

    localparam int unsigned CW = $clog2(PD_MIN_CYC + 1);

    logic [CW-1:0] low_q;

    // Count consecutive low cycles, saturating at the minimum pulse length.
    always_ff @(posedge clk) begin
        if (!rst_n || pin_s)
            low_q <= '0;
        else if (low_q != CW'(PD_MIN_CYC))
            low_q <= low_q + 1'b1;
    end

    assign pd_act = (low_q == CW'(PD_MIN_CYC));

endmodule

// File: rtl/css_wake_timer.sv
// Loadable down-counter used for the source-specific wake-up delay.
// 'zero' is high when the count has expired.
// Assumes: the load value is the delay minus one.
module css_wake_timer #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    output logic          zero
);

    logic [DW-1:0] cnt_q;

    // Load on request, otherwise count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/clk_src_sel.sv
// Top of the clock source selector. After reset or a valid power-down it
// measures the external clock pin against the reference clock. It then picks
// the external source or the internal oscillator, waits for the delay that
// belongs to that source, and raises clk_ready. The decision is held until
// the next valid power-down.
// Assumes: clk is the internal-oscillator reference, running whenever the block
// needs it, and xtal_fitted is a static strap.
module clk_src_sel #(
    parameter int unsigned WIN_CYC      = 4096,
    parameter int unsigned EDGE_THR     = 250,
    parameter int unsigned PD_MIN_CYC   = 128,
    parameter int unsigned DLY_EXT_CYC  = 1,
    parameter int unsigned DLY_INT_CYC  = 39,
    parameter int unsigned DLY_XTAL_CYC = 27525
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_on_pin,
    input  logic ext_clk_pin,
    input  logic xtal_fitted,
    output logic use_ext_clk,
    output logic int_osc_en,
    output logic xtal_amp_en,
    output logic clk_ready
);

    import css_pkg::*;

    localparam int unsigned DLY_MAX = css_max3(DLY_EXT_CYC, DLY_INT_CYC, DLY_XTAL_CYC);
    localparam int unsigned DW      = (DLY_MAX > 1) ? $clog2(DLY_MAX) : 1;

    css_state_t    state_q, state_d;
    logic [1:0]    pins_s;
    logic          pwr_s, ext_s;
    logic          pd_act;
    logic          meter_done, meter_found;
    logic          tmr_zero;
    logic [DW-1:0] dly_val;
    logic          ext_sel_q;
    logic          selected;

    css_sync #(.W(2), .RST_VAL(2'b10)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({pwr_on_pin, ext_clk_pin}),
        .q     (pins_s)
    );
    assign pwr_s = pins_s[1];
    assign ext_s = pins_s[0];

    css_pd_filter #(.PD_MIN_CYC(PD_MIN_CYC)) u_pd (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_s  (pwr_s),
        .pd_act (pd_act)
    );

    css_edge_meter #(.WIN_CYC(WIN_CYC), .EDGE_THR(EDGE_THR)) u_meter (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (state_q == CSS_DETECT),
        .sig    (ext_s),
        .done   (meter_done),
        .found  (meter_found)
    );

    // Pick the wake-up delay from the decision being taken.
    always_comb begin
        if (!meter_found)     dly_val = DW'(DLY_INT_CYC - 1);
        else if (xtal_fitted) dly_val = DW'(DLY_XTAL_CYC - 1);
        else                  dly_val = DW'(DLY_EXT_CYC - 1);
    end

    css_wake_timer #(.DW(DW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (meter_done),
        .load_val (dly_val),
        .zero     (tmr_zero)
    );

    // Next-state logic; a qualified power-down overrides every state.
    always_comb begin
        state_d = state_q;
        if (pd_act) begin
            state_d = CSS_OFF;
        end else begin
            case (state_q)
                CSS_OFF:    state_d = CSS_DETECT;
                CSS_DETECT: if (meter_done) state_d = CSS_WAKE;
                CSS_WAKE:   if (tmr_zero)   state_d = CSS_RUN;
                default:    state_d = CSS_RUN;
            endcase
        end
    end

    // State register; reset behaves as a fresh power-up into detection.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CSS_DETECT;
        else        state_q <= state_d;
    end

    // Latch the source decision at the end of the window, clear it on power-down.
    always_ff @(posedge clk) begin
        if (!rst_n || pd_act || state_q == CSS_OFF)
            ext_sel_q <= 1'b0;
        else if (meter_done)
            ext_sel_q <= meter_found;
    end

    assign selected    = (state_q == CSS_WAKE) || (state_q == CSS_RUN);
    assign use_ext_clk = ext_sel_q;
    assign clk_ready   = (state_q == CSS_RUN);
    assign int_osc_en  = (state_q == CSS_DETECT) || (selected && !ext_sel_q);
    assign xtal_amp_en = xtal_fitted &&
                         ((state_q == CSS_DETECT) || (selected && ext_sel_q));

endmodule

// File: rtl/clk_src_sel_chk.sv
// Property checker for the clock source selector, bound to the top module.
// Assumes: reset is asserted at time zero.
module clk_src_sel_chk (
    input logic                clk,
    input logic                rst_n,
    input css_pkg::css_state_t state_q,
    input logic                pd_act,
    input logic                use_ext_clk,
    input logic                int_osc_en,
    input logic                xtal_amp_en,
    input logic                clk_ready
);
    import css_pkg::*;

    p_detect_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CSS_DETECT) |-> (!clk_ready && !use_ext_clk && int_osc_en));

    p_ext_osc_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_ready && use_ext_clk) |-> !int_osc_en);

    p_int_osc_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_ready && !use_ext_clk) |-> int_osc_en);

    p_hold_choice_r4: assert property (@(posedge clk) disable iff (!rst_n || pd_act)
        (clk_ready && $past(clk_ready)) |-> $stable(use_ext_clk));

    p_pd_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pd_act |=> (!clk_ready && !int_osc_en && !xtal_amp_en && !use_ext_clk));

    p_ready_after_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_ready) |-> ($past(state_q) == CSS_WAKE));

endmodule

bind clk_src_sel clk_src_sel_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state_q     (state_q),
    .pd_act      (pd_act),
    .use_ext_clk (use_ext_clk),
    .int_osc_en  (int_osc_en),
    .xtal_amp_en (xtal_amp_en),
    .clk_ready   (clk_ready)
);

// File: tb/clk_src_sel_tb.sv
// Scoreboard bench: driver tasks queue the expected wake-up outcome, and a monitor
// pops it when clk_ready rises and compares the selection and latency.
module clk_src_sel_tb;

    localparam int WIN  = 64;
    localparam int THR  = 8;
    localparam int PDM  = 6;
    localparam int DEXT = 2;
    localparam int DINT = 10;
    localparam int DXTL = 40;

    logic clk = 1'b0;
    logic rst_n, pwr_on_pin, ext_clk_pin, xtal_fitted;
    logic use_ext_clk, int_osc_en, xtal_amp_en, clk_ready;

    always #5 clk = ~clk;

    clk_src_sel #(
        .WIN_CYC(WIN), .EDGE_THR(THR), .PD_MIN_CYC(PDM),
        .DLY_EXT_CYC(DEXT), .DLY_INT_CYC(DINT), .DLY_XTAL_CYC(DXTL)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_on_pin(pwr_on_pin),
        .ext_clk_pin(ext_clk_pin), .xtal_fitted(xtal_fitted),
        .use_ext_clk(use_ext_clk), .int_osc_en(int_osc_en),
        .xtal_amp_en(xtal_amp_en), .clk_ready(clk_ready)
    );

    typedef struct {
        string req;
        int    sel, osc, xtl, lo, hi;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0, n_fail = 0;
    int   cyc = 0, t_ref = 0, served = 0, drops = 0;
    int   ext_half = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // External pin stimulus: half period in clk cycles, 0 = tied low.
    initial begin
        ext_clk_pin = 1'b0;
        forever begin
            if (ext_half == 0) begin
                ext_clk_pin = 1'b0;
                @(negedge clk);
            end else begin
                repeat (ext_half) @(negedge clk);
                ext_clk_pin = ~ext_clk_pin;
            end
        end
    end

    // Monitor: compare each rise of clk_ready with the queued expectation, count falls.
    initial begin
        logic prev;
        prev = 1'b0;
        forever begin
            @(negedge clk);
            if (clk_ready && !prev) begin
                if (q.size() == 0) begin
                    chk("R6", "unexpected ready rise", 1, 0);
                end else begin
                    exp_t e;
                    int   el;
                    e  = q.pop_front();
                    el = cyc - t_ref;
                    n_chk++;
                    if (el < e.lo || el > e.hi) begin
                        n_fail++;
                        $display("FAIL R8 %s latency: actual %0d expected %0d..%0d", e.req, el, e.lo, e.hi);
                    end
                    chk(e.req, "use_ext_clk", int'(use_ext_clk), e.sel);
                    chk(e.req, "int_osc_en", int'(int_osc_en), e.osc);
                    chk("R9", "xtal_amp_en", int'(xtal_amp_en), e.xtl);
                end
                served++;
            end
            if (!clk_ready && prev) drops++;
            prev = clk_ready;
        end
    end

    task automatic arm(input string req, input int sel, input int xtl, input int d);
        exp_t e;
        e.req = req; e.sel = sel; e.osc = 1 - sel; e.xtl = xtl;
        e.lo = WIN + d; e.hi = WIN + d + 6;
        q.push_back(e);
        t_ref = cyc;
    endtask

    task automatic wait_served(input int target);
        while (served < target) @(negedge clk);
    endtask

    // Long power-down with a new pin setup, then wake and expect an outcome.
    task automatic power_cycle(input string req, input int half, input logic xt,
                               input int sel, input int xtl, input int d);
        int tgt;
        tgt = served + 1;
        @(negedge clk);
        pwr_on_pin  = 1'b0;
        ext_half    = half;
        xtal_fitted = xt;
        repeat (PDM + 4) @(negedge clk);
        chk("R5", "ready during power-down", int'(clk_ready), 0);
        chk("R5", "osc during power-down", int'(int_osc_en), 0);
        chk("R5", "xtal during power-down", int'(xtal_amp_en), 0);
        chk("R5", "sel during power-down", int'(use_ext_clk), 0);
        arm(req, sel, xtl, d);
        pwr_on_pin = 1'b1;
        wait_served(tgt);
    endtask

    initial begin
        rst_n = 1'b0; pwr_on_pin = 1'b1; xtal_fitted = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1", "ready in reset", int'(clk_ready), 0);
        chk("R1", "sel in reset", int'(use_ext_clk), 0);
        chk("R1", "osc in reset", int'(int_osc_en), 1);

        // R3/R8: idle pin from power-up gives the internal oscillator.
        arm("R3", 0, 0, DINT);
        rst_n = 1'b1;
        wait_served(1);

        // R2/R7/R8: fast clock (period 4, about 16 edges) after power-down.
        power_cycle("R2", 2, 1'b0, 1, 0, DEXT);

        // R4: the pin stops after selection; nothing changes.
        ext_half = 0;
        repeat (150) @(negedge clk);
        chk("R4", "ready held", int'(clk_ready), 1);
        chk("R4", "sel held", int'(use_ext_clk), 1);
        chk("R4", "osc held off", int'(int_osc_en), 0);

        // R6: a pulse one cycle short of the minimum is ignored.
        begin
            int d0;
            d0 = drops;
            @(negedge clk);
            pwr_on_pin = 1'b0;
            repeat (PDM - 1) @(negedge clk);
            pwr_on_pin = 1'b1;
            repeat (20) @(negedge clk);
            chk("R6", "ready drops", drops, d0);
            chk("R6", "ready", int'(clk_ready), 1);
            chk("R6", "sel", int'(use_ext_clk), 1);
        end

        // R9/R8: crystal fitted and oscillating (period 6) gives the long delay.
        power_cycle("R9", 3, 1'b1, 1, 1, DXTL);

        // R9/R3: crystal fitted but silent falls back to internal.
        power_cycle("R9", 0, 1'b1, 0, 0, DINT);

        // R3: slow clock (period 12, about 5 edges) stays internal.
        power_cycle("R3", 6, 1'b0, 0, 0, DINT);

        // R5/R7: a pulse of exactly the minimum length tears down and re-detects.
        begin
            int d0, tgt;
            d0  = drops;
            tgt = served + 1;
            @(negedge clk);
            pwr_on_pin = 1'b0;
            ext_half   = 2;
            xtal_fitted = 1'b0;
            repeat (PDM) @(negedge clk);
            arm("R7", 1, 0, DEXT);
            pwr_on_pin = 1'b1;
            repeat (8) @(negedge clk);
            chk("R5", "minimum pulse drops ready", drops, d0 + 1);
            wait_served(tgt);
        end

        repeat (10) @(negedge clk);
        chk("R4", "queue drained", q.size(), 0);
        finish_run();
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule